// File: doc/BRIEF.md
# Interleaved Buck/Boost PWM Timing Generator

This block derives all switching instants for a three-phase power controller from one system clock. A single period counter produces a start tick for buck phase A, a second start tick for buck phase B placed half a period later, and a start tick for a boost phase that runs at one third of the buck rate. On each start tick the matching gate request rises. It falls again when the analog loop's terminate comparator fires. A terminate that comes before a minimum on-time has elapsed is ignored, and every pulse is cut at a per-phase duty ceiling.

Each buck phase also takes an out-of-range flag from its error amplifier. The flag is sampled at that phase's start ticks. Once it has been seen high on two start ticks in a row and is still high, the phase's ceiling drops to a shorter clamp length. The clamp releases in the same cycle the flag drops. A per-phase disable forces that gate low and leaves the shared counters running. All lengths are counts of system-clock cycles, set by parameters.

Top module: `pwm_timing_gen`

## Requirements
- R1: `buck_tick[0]` is a one-cycle pulse every PERIOD cycles. The first pulse comes PERIOD-1 cycles after reset is released.
- R2: With INTERLEAVE set, `buck_tick[1]` pulses PERIOD/2 cycles after each `buck_tick[0]` and never in the same cycle.
- R3: `boost_tick` pulses together with every third `buck_tick[0]`, starting with the third one after reset.
- R4: An enabled gate rises in the cycle after its phase tick. A gate never rises at any other time.
- R5: A terminate seen while the gate has been high for k >= MIN_ON cycles ends the pulse with a width of exactly k cycles. A terminate seen while k < MIN_ON has no effect.
- R6: A buck pulse with no accepted terminate and no clamp lasts exactly MAX_ON cycles.
- R7: A boost pulse lasts at most BOOST_ON cycles, which is one third of its period by default. With no terminate it lasts exactly BOOST_ON cycles.
- R8: The buck clamp is active only while the out-of-range flag is high and the flag was also high at the phase's last PERSIST start ticks (2 by default). An active clamp cuts the pulse at CLAMP_ON cycles.
- R9: When the out-of-range flag drops, the clamp releases at once. A pulse that is still running then ends at the MAX_ON limit.
- R10: While a phase's disable is high, that gate is low from the next cycle on. All ticks keep their timing.
- R11: While reset is asserted, all ticks and gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buck_term | input | 2 | Terminate requests for buck phases A (bit 0) and B (bit 1) |
| boost_term | input | 1 | Terminate request for the boost phase |
| buck_oor | input | 2 | Error-amplifier out-of-range flags, one per buck phase |
| buck_dis | input | 2 | Per-buck-phase gate disable |
| boost_dis | input | 1 | Boost gate disable |
| buck_tick | output | 2 | Start ticks of buck phases A and B |
| boost_tick | output | 1 | Start tick of the boost phase |
| buck_gate | output | 2 | PWM gate requests of buck phases A and B |
| boost_gate | output | 1 | PWM gate request of the boost phase |

## Verification
The assertions check the per-cycle relations on every cycle. These are: the two buck ticks never coincide, and every boost tick lands on a phase-A tick. A gate rises only after its own tick, and a disable forces its gate low in the next cycle. A high gate never outlasts its ceiling, and a gate that falls on its own has been high for at least the minimum on-time. Three things need the bench's scenarios and its cycle model: the exact pulse widths produced by a terminate, the two-tick persistence before the clamp engages, and the immediate release of the clamp when the flag drops mid-pulse.

// File: rtl/pwmtg_pkg.sv
package pwmtg_pkg;

   // bits needed to hold values 0..maxval, never less than one
   function automatic int cnt_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwmtg_phase_clock.sv
module pwmtg_phase_clock #(
   parameter int PERIOD     = 40,
   parameter int BOOST_DIV  = 3,
   parameter bit INTERLEAVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_a,
   output logic tick_b,
   output logic tick_boost
);
   import pwmtg_pkg::*;

   localparam int CW   = cnt_width(PERIOD - 1);
   localparam int DW   = cnt_width(BOOST_DIV - 1);
   localparam int HALF = PERIOD / 2;

   logic [CW-1:0] per_q;
   logic [DW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
      end else if (per_q == CW'(PERIOD - 1)) begin
         per_q <= '0;
      end else begin
         per_q <= per_q + 1'b1;
      end
   end

   assign tick_a = rst_n && (per_q == CW'(PERIOD - 1));

   generate
      if (INTERLEAVE) begin : g_shift
         assign tick_b = rst_n && (per_q == CW'(HALF - 1));
      end else begin : g_aligned
         assign tick_b = tick_a;
      end
   endgenerate

   // boost rate divider counts phase-A ticks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (tick_a) begin
         if (div_q == DW'(BOOST_DIV - 1)) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign tick_boost = tick_a && (div_q == DW'(BOOST_DIV - 1));

endmodule

// File: rtl/pwmtg_clamp_filter.sv
module pwmtg_clamp_filter #(
   parameter int PERSIST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic flag,
   output logic clamp
);
   import pwmtg_pkg::*;

   localparam int PW = cnt_width(PERSIST);

   logic [PW-1:0] seen_q;

   // consecutive start ticks on which the flag was high, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (sample) begin
         if (!flag) begin
            seen_q <= '0;
         end else if (seen_q != PW'(PERSIST)) begin
            seen_q <= seen_q + 1'b1;
         end
      end
   end

   assign clamp = flag && (seen_q == PW'(PERSIST));

endmodule

// File: rtl/pwmtg_pulse_shaper.sv
module pwmtg_pulse_shaper #(
   parameter int MIN_ON   = 4,
   parameter int MAX_ON   = 30,
   parameter int CLAMP_ON = 12,
   parameter int OW       = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic term,
   input  logic dis,
   input  logic clamp,
   output logic gate
);
   logic [OW-1:0] on_q;
   logic [OW-1:0] limit;
   logic          term_ok;
   logic          stop;

   assign limit   = clamp ? OW'(CLAMP_ON) : OW'(MAX_ON);
   assign term_ok = term && (on_q >= OW'(MIN_ON));
   assign stop    = term_ok || (on_q >= limit);

   // on_q holds the number of cycles the gate has been high so far
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= 1'b0;
         on_q <= '0;
      end else if (dis) begin
         gate <= 1'b0;
         on_q <= '0;
      end else if (start) begin
         gate <= 1'b1;
         on_q <= OW'(1);
      end else if (gate) begin
         if (stop) begin
            gate <= 1'b0;
            on_q <= '0;
         end else begin
            on_q <= on_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwm_timing_gen.sv
module pwm_timing_gen #(
   parameter int PERIOD     = 40,
   parameter int MIN_ON     = 4,
   parameter int MAX_ON     = 30,
   parameter int CLAMP_ON   = 12,
   parameter int BOOST_DIV  = 3,
   parameter int BOOST_ON   = 40,
   parameter int PERSIST    = 2,
   parameter bit INTERLEAVE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] buck_term,
   input  logic       boost_term,
   input  logic [1:0] buck_oor,
   input  logic [1:0] buck_dis,
   input  logic       boost_dis,
   output logic [1:0] buck_tick,
   output logic       boost_tick,
   output logic [1:0] buck_gate,
   output logic       boost_gate
);
   import pwmtg_pkg::*;

   localparam int LIM_MAX = max3(MAX_ON, CLAMP_ON, BOOST_ON);
   localparam int OW      = cnt_width(LIM_MAX);

   // elaboration-time parameter checks
   generate
      if (PERIOD < 4) begin : g_bad_period
         $error("PERIOD must be at least 4");
      end
      if (MAX_ON >= PERIOD) begin : g_bad_max
         $error("MAX_ON must be shorter than PERIOD");
      end
      if (CLAMP_ON < MIN_ON || CLAMP_ON > MAX_ON) begin : g_bad_clamp
         $error("CLAMP_ON must lie between MIN_ON and MAX_ON");
      end
      if (MIN_ON < 1) begin : g_bad_min
         $error("MIN_ON must be at least 1");
      end
      if (BOOST_DIV < 1 || BOOST_ON < MIN_ON || BOOST_ON >= PERIOD * BOOST_DIV) begin : g_bad_boost
         $error("boost divider or boost ceiling out of range");
      end
      if (PERSIST < 1) begin : g_bad_persist
         $error("PERSIST must be at least 1");
      end
   endgenerate

   logic       tick_a;
   logic       tick_b;
   logic [1:0] clamp_w;

   pwmtg_phase_clock #(
      .PERIOD    (PERIOD),
      .BOOST_DIV (BOOST_DIV),
      .INTERLEAVE(INTERLEAVE)
   ) u_clock (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_a    (tick_a),
      .tick_b    (tick_b),
      .tick_boost(boost_tick)
   );

   assign buck_tick = {tick_b, tick_a};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_buck
         pwmtg_clamp_filter #(
            .PERSIST(PERSIST)
         ) u_filter (
            .clk   (clk),
            .rst_n (rst_n),
            .sample(buck_tick[g]),
            .flag  (buck_oor[g]),
            .clamp (clamp_w[g])
         );

         pwmtg_pulse_shaper #(
            .MIN_ON  (MIN_ON),
            .MAX_ON  (MAX_ON),
            .CLAMP_ON(CLAMP_ON),
            .OW      (OW)
         ) u_shaper (
            .clk  (clk),
            .rst_n(rst_n),
            .start(buck_tick[g]),
            .term (buck_term[g]),
            .dis  (buck_dis[g]),
            .clamp(clamp_w[g]),
            .gate (buck_gate[g])
         );
      end
   endgenerate

   pwmtg_pulse_shaper #(
      .MIN_ON  (MIN_ON),
      .MAX_ON  (BOOST_ON),
      .CLAMP_ON(BOOST_ON),
      .OW      (OW)
   ) u_boost (
      .clk  (clk),
      .rst_n(rst_n),
      .start(boost_tick),
      .term (boost_term),
      .dis  (boost_dis),
      .clamp(1'b0),
      .gate (boost_gate)
   );

endmodule

// File: rtl/pwm_timing_gen_chk.sv
module pwm_timing_gen_chk #(
   parameter int MIN_ON   = 4,
   parameter int MAX_ON   = 30,
   parameter int BOOST_ON = 40,
   parameter int RW       = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] buck_dis,
   input logic       boost_dis,
   input logic [1:0] buck_tick,
   input logic       boost_tick,
   input logic [1:0] buck_gate,
   input logic       boost_gate
);
   logic [2:0]    gates;
   logic [2:0]    dis_all;
   logic [2:0]    ticks;
   logic [RW-1:0] run_q [3];

   assign gates   = {boost_gate, buck_gate};
   assign dis_all = {boost_dis, buck_dis};
   assign ticks   = {boost_tick, buck_tick};

   // length of the current or just-finished high run of each gate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) run_q[i] <= '0;
      end else begin
         for (int i = 0; i < 3; i++) run_q[i] <= gates[i] ? run_q[i] + 1'b1 : '0;
      end
   end

   assert_tick_sep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(buck_tick[0] && buck_tick[1]));

   assert_boost_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      boost_tick |-> buck_tick[0]);

   assert_boost_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boost_gate |-> (run_q[2] < RW'(BOOST_ON)));

   generate
      for (genvar p = 0; p < 3; p++) begin : g_all
         assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gates[p]) |-> $past(ticks[p]));

         assert_min_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(gates[p]) && !$past(dis_all[p])) |-> (run_q[p] >= RW'(MIN_ON)));

         assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            dis_all[p] |=> !gates[p]);
      end
      for (genvar b = 0; b < 2; b++) begin : g_buck
         assert_max_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
            buck_gate[b] |-> (run_q[b] < RW'(MAX_ON)));
      end
   endgenerate

endmodule

bind pwm_timing_gen pwm_timing_gen_chk #(
   .MIN_ON  (MIN_ON),
   .MAX_ON  (MAX_ON),
   .BOOST_ON(BOOST_ON)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .buck_dis  (buck_dis),
   .boost_dis (boost_dis),
   .buck_tick (buck_tick),
   .boost_tick(boost_tick),
   .buck_gate (buck_gate),
   .boost_gate(boost_gate)
);

// File: tb/sim_pwm_timing_gen.sv
module sim_pwm_timing_gen;
   localparam int P     = 40;
   localparam int MINON = 4;
   localparam int MAXON = 30;
   localparam int CLMP  = 12;
   localparam int BDIV  = 3;
   localparam int BON   = 40;
   localparam int PERS  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] buck_term = '0;
   logic       boost_term = 1'b0;
   logic [1:0] buck_oor = '0;
   logic [1:0] buck_dis = '0;
   logic       boost_dis = 1'b0;
   logic [1:0] buck_tick;
   logic       boost_tick;
   logic [1:0] buck_gate;
   logic       boost_gate;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;  // 125 MHz

   pwm_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .buck_term(buck_term), .boost_term(boost_term),
      .buck_oor(buck_oor), .buck_dis(buck_dis), .boost_dis(boost_dis),
      .buck_tick(buck_tick), .boost_tick(boost_tick),
      .buck_gate(buck_gate), .boost_gate(boost_gate)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // ---------------- reference model, built from the requirements ----------------
   int m_cnt, m_div;
   int m_seen [2];
   bit m_gate [3];
   int m_on [3];

   function automatic int limit_of(input int p, input bit clamp);
      if (p == 2) return BON;
      return clamp ? CLMP : MAXON;
   endfunction

   function automatic bit e_tick(input int p);
      if (p == 0) return m_cnt == P - 1;
      if (p == 1) return m_cnt == P / 2 - 1;
      return (m_cnt == P - 1) && (m_div == BDIV - 1);
   endfunction

   function automatic bit e_clamp(input int p);
      if (p == 2) return 1'b0;
      return buck_oor[p] && (m_seen[p] == PERS);
   endfunction

   function automatic bit term_of(input int p);
      return (p == 2) ? boost_term : buck_term[p];
   endfunction

   function automatic bit dis_of(input int p);
      return (p == 2) ? boost_dis : buck_dis[p];
   endfunction

   function automatic bit gate_of(input int p);
      return (p == 2) ? boost_gate : buck_gate[p];
   endfunction

   function automatic bit tick_of(input int p);
      return (p == 2) ? boost_tick : buck_tick[p];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_div <= 0;
         for (int i = 0; i < 2; i++) m_seen[i] <= 0;
         for (int p = 0; p < 3; p++) begin m_gate[p] <= 1'b0; m_on[p] <= 0; end
      end else begin
         m_cnt <= (m_cnt == P - 1) ? 0 : m_cnt + 1;
         if (e_tick(0)) m_div <= (m_div == BDIV - 1) ? 0 : m_div + 1;
         for (int i = 0; i < 2; i++)
            if (e_tick(i)) m_seen[i] <= !buck_oor[i] ? 0 : ((m_seen[i] >= PERS) ? PERS : m_seen[i] + 1);
         for (int p = 0; p < 3; p++) begin
            if (dis_of(p)) begin
               m_gate[p] <= 1'b0; m_on[p] <= 0;
            end else if (e_tick(p)) begin
               m_gate[p] <= 1'b1; m_on[p] <= 1;
            end else if (m_gate[p]) begin
               if ((term_of(p) && m_on[p] >= MINON) || m_on[p] >= limit_of(p, e_clamp(p))) begin
                  m_gate[p] <= 1'b0; m_on[p] <= 0;
               end else begin
                  m_on[p] <= m_on[p] + 1;
               end
            end
         end
      end
   end

   // cycle-by-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(buck_tick[0] == e_tick(0), "R1 tick A", buck_tick[0], e_tick(0));
         check(buck_tick[1] == e_tick(1), "R2 tick B", buck_tick[1], e_tick(1));
         check(boost_tick == e_tick(2), "R3 boost tick", boost_tick, e_tick(2));
         for (int p = 0; p < 3; p++)
            check(gate_of(p) == m_gate[p], "R4/R5/R6/R7/R8 gate model", gate_of(p), m_gate[p]);
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   // ---------------- directed helpers ----------------
   task automatic set_term(input int p, input bit v);
      if (p == 2) boost_term = v; else buck_term[p] = v;
   endtask

   // measure the next pulse of phase p; pulse a terminate when width reaches
   // term_at, drop that phase's flag when width reaches clr_at
   task automatic measure(input int p, input int term_at, input int clr_at, output int w);
      w = 0;
      while (gate_of(p)) @(negedge clk);
      do @(negedge clk); while (!gate_of(p));
      while (gate_of(p)) begin
         w++;
         #1;
         set_term(p, w == term_at);
         if (w == clr_at && p < 2) buck_oor[p] = 1'b0;
         @(negedge clk);
      end
      #1 set_term(p, 1'b0);
   endtask

   initial begin
      int w, k, na, hi, nb;
      void'($urandom(32'd20240611));

      // R11: reset state
      repeat (3) @(negedge clk);
      check(buck_tick == 2'b00 && !boost_tick, "R11 ticks in reset", {boost_tick, buck_tick}, 0);
      check(buck_gate == 2'b00 && !boost_gate, "R11 gates in reset", {boost_gate, buck_gate}, 0);
      #1 rst_n = 1'b1;

      // R1: first tick after release
      k = 0;
      do begin @(negedge clk); k++; end while (!buck_tick[0] && k < 2 * P);
      check(k == P - 1, "R1 first tick delay", k, P - 1);

      // R2: B tick half a period after A; R1: period
      k = 0;
      do begin @(negedge clk); k++; end while (!buck_tick[1]);
      check(k == P / 2, "R2 A-to-B spacing", k, P / 2);
      do begin @(negedge clk); k++; end while (!buck_tick[0]);
      check(k == P, "R1 tick period", k, P);

      // R3: boost every third A tick
      do @(negedge clk); while (!boost_tick);
      na = 0;
      do begin @(negedge clk); if (buck_tick[0]) na++; end while (!boost_tick);
      check(na == BDIV, "R3 A ticks per boost tick", na, BDIV);

      // R4/R6: free-running pulses, then the rise follows the tick by one cycle
      do @(negedge clk); while (!buck_tick[0]);
      @(negedge clk);
      check(buck_gate[0] == 1'b1, "R4 rise after tick", buck_gate[0], 1);
      measure(0, 0, 0, w);
      check(w == MAXON, "R6 unterminated buck width", w, MAXON);

      // R5: accepted and ignored terminates
      measure(1, 10, 0, w);
      check(w == 10, "R5 terminate width", w, 10);
      measure(1, MINON, 0, w);
      check(w == MINON, "R5 terminate at minimum", w, MINON);
      measure(0, MINON - 1, 0, w);
      check(w == MAXON, "R5 early terminate ignored", w, MAXON);

      // R7: boost ceiling and terminate
      measure(2, 0, 0, w);
      check(w == BON, "R7 boost ceiling", w, BON);
      measure(2, 15, 0, w);
      check(w == 15, "R7 boost terminate", w, 15);

      // R8: clamp after two ticks with the flag high
      #1 buck_oor[0] = 1'b1;
      measure(0, 0, 0, w);
      check(w == MAXON, "R8 one tick not enough", w, MAXON);
      measure(0, 0, 0, w);
      check(w == CLMP, "R8 clamped width", w, CLMP);
      // R9: release mid-pulse
      measure(0, 0, CLMP - 2, w);
      check(w == MAXON, "R9 clamp release mid-pulse", w, MAXON);
      measure(0, 0, 0, w);
      check(w == MAXON, "R9 width after release", w, MAXON);

      // R10: disable holds gate low, ticks continue
      do @(negedge clk); while (!buck_tick[0]);
      #1 buck_dis[0] = 1'b1;
      hi = 0; na = 0; nb = 0;
      @(negedge clk);
      for (int i = 0; i < 2 * P; i++) begin
         if (buck_gate[0]) hi++;
         if (buck_tick[0]) na++;
         if (buck_gate[1]) nb++;
         @(negedge clk);
      end
      check(hi == 0, "R10 gate held low", hi, 0);
      check(na == 2, "R10 ticks unaffected", na, 2);
      check(nb > 0, "R10 other phase still pulses", nb, 1);
      #1 buck_dis[0] = 1'b0;

      // random mix checked against the model
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         #1;
         buck_term  = 2'($urandom_range(0, 3) & {1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0)});
         boost_term = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 59) == 0) buck_oor[0] = ~buck_oor[0];
         if ($urandom_range(0, 59) == 0) buck_oor[1] = ~buck_oor[1];
         if ($urandom_range(0, 199) == 0) buck_dis[0] = ~buck_dis[0];
         if ($urandom_range(0, 199) == 0) buck_dis[1] = ~buck_dis[1];
         if ($urandom_range(0, 299) == 0) boost_dis = ~boost_dis;
      end

      // R11: reset again mid-activity
      #1 rst_n = 1'b0;
      @(negedge clk);
      check(buck_gate == 2'b00 && !boost_gate, "R11 gates after reset", {boost_gate, buck_gate}, 0);
      finish_run();
   end
endmodule